// File: doc/BRIEF.md
# Continuous-Fill Nine-Bit Serial Transmitter

This block is an asynchronous serial transmitter for links where the line must keep toggling for as long as the transmitter is enabled. Bursts of activity followed by silence couple noise into nearby analog circuits, so the line is never left idle. Bytes written through a small FIFO go out as nine-bit frames with the ninth bit at 1. Whenever there is no payload ready, the block sends a programmable fill byte with the ninth bit at 0. A receiver that only accepts frames with the ninth bit set will see only the payload.

Bit timing comes from a divisor register with 16x oversampling: one bit lasts (divisor+1)*16 clocks. Software computes the divisor as the rounded value of clk/(16*baud) minus one. A frame carries optional parity, selectable as even or odd and computed over all nine data bits, and one or two stop bits. An optional clear-to-send input holds payload back. While it is low, fill frames are sent instead and the FIFO keeps its contents. When the block is disabled, the output enable drops and the line is left to an external pull-up.

The controller is a state machine with these states: `ST_OFF`, `ST_START`, `ST_DATA`, `ST_NINTH`, `ST_PARITY`, `ST_STOP1` and `ST_STOP2`. Its transitions are:

- `ST_OFF` goes to `ST_START` when enable is high. It loads a frame on that edge.
- `ST_START` goes to `ST_DATA`.
- `ST_DATA` stays in place for eight bits, then goes to `ST_NINTH`.
- `ST_NINTH` goes to `ST_PARITY` if parity is on, otherwise to `ST_STOP1`.
- `ST_PARITY` goes to `ST_STOP1`.
- `ST_STOP1` goes to `ST_STOP2` if two stop bits were chosen.
- The last stop bit goes back to `ST_START`, loading the next frame, if enable is high. Otherwise it goes to `ST_OFF`.

Every transition out of a non-off state happens at the end of a bit period.

Top module: `fill_uart_tx`

## Requirements
- R1: While enabled and the FIFO is empty, the block sends frames that carry `fill_byte` as data with the ninth bit at 0.
- R2: Each byte taken from the FIFO is sent with the ninth bit at 1, in the order the bytes were written.
- R3: A frame consists of the following bits, in order:
  - one start bit at 0;
  - eight data bits, least significant bit first;
  - the ninth bit;
  - the parity bit, if parity is on;
  - the stop bits at 1.
- R4: Every bit lasts exactly (`divisor`+1)*16 clocks. While enable stays high, a new frame's start bit follows the last stop bit with no gap.
- R5: With `hs_en` at 1 and `cts` at 0 at a frame boundary, no byte is taken from the FIFO and a fill frame is sent instead. Payload resumes at the first boundary with `cts` at 1, and a frame already on the line is never cut.
- R6: `parity_mode` is sampled when a frame is loaded:
  - 2'b00 and 2'b11 send no parity bit;
  - 2'b01 sends even parity;
  - 2'b10 sends odd parity.
  Parity covers the eight data bits and the ninth bit.
- R7: With `two_stop` at 1 when a frame is loaded, the frame ends with two stop bits instead of one.
- R8: When enable falls, the frame in flight completes. After its last stop bit, `txd_oe` is 0 and `txd` is 1. Once enable rises again, the start bit appears in the next cycle.
- R9: The FIFO holds `FIFO_DEPTH` bytes. `fifo_empty` and `fifo_full` reflect its fill one cycle after a write or pop, and a byte is popped only when a frame is loaded.
- R10: A write while `fifo_full` is 1 is ignored and leaves the FIFO contents unchanged.
- R11: After reset, `txd_oe` is 0, `txd` is 1, `fifo_empty` is 1 and `fifo_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Transmitter enable |
| wr_en | input | 1 | Write strobe for the FIFO |
| wr_data | input | DATA_W | Byte to queue |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| divisor | input | DIV_W | Bit period divisor: a bit lasts (divisor+1)*16 clocks |
| parity_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| two_stop | input | 1 | Send two stop bits |
| fill_byte | input | DATA_W | Data sent in fill frames |
| hs_en | input | 1 | Enable clear-to-send flow control |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial data |
| txd_oe | output | 1 | Output driver enable |

## Verification
The bench chases four kinds of error:

- **Boundary slips.** The bench checks frames that run back to back, where the load of a new frame coincides with the end of the last stop bit. A design that inserted one idle cycle, or stretched a bit, would shift every following bit against the reference.
- **Blocked flow control.** It holds `cts` low with a full FIFO and toggles it in mid-frame. A design that popped while blocked would put payload with the ninth bit at 1 where a fill frame is expected. A design that aborted a frame would show a truncated stop bit.
- **Writes to a full FIFO.** Extra bytes are written while the FIFO is full. An implementation that accepted them would send an extra payload frame later.
- **Encodings and shutdown.** It walks every parity encoding with ninth bits of both values, then disables the block in mid-frame to confirm the driver releases only after the stop bit.

// File: rtl/fill_tx_pkg.sv
package fill_tx_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_t;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

    function automatic logic parity_on(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

endpackage

// File: rtl/fill_tx_fifo.sv
module fill_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/fill_tx_baud.sv
module fill_tx_baud #(
    parameter int DIV_W = 16,
    parameter int OS    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_done
);
    localparam int OSW = $clog2(OS);

    logic [DIV_W-1:0] div_cnt;
    logic [OSW-1:0]   os_cnt;
    logic             os_tick;

    assign os_tick  = run && (div_cnt == divisor);
    assign bit_done = os_tick && (os_cnt == OSW'(OS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            os_cnt  <= '0;
        end else if (!run) begin
            div_cnt <= '0;
            os_cnt  <= '0;
        end else if (os_tick) begin
            div_cnt <= '0;
            os_cnt  <= bit_done ? '0 : os_cnt + 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fill_tx_fsm.sv
module fill_tx_fsm
    import fill_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         bit_done,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_head,
    input  logic [W-1:0] fill_byte,
    input  logic         hs_en,
    input  logic         cts,
    input  logic [1:0]   parity_mode,
    input  logic         two_stop,
    output logic         fifo_pop,
    output logic         run,
    output logic         txd,
    output logic         txd_oe
);
    localparam int IDXW = (W > 1) ? $clog2(W) : 1;

    tx_state_t     state, state_nx;
    logic [W-1:0]  shreg;
    logic [IDXW-1:0] idx;
    logic          ninth, par_bit, par_en, stop2;
    logic          frame_end, load, take;
    logic [W-1:0]  next_byte;
    logic          next_ninth;

    assign frame_end  = bit_done && ((state == ST_STOP2) || (state == ST_STOP1 && !stop2));
    assign load       = enable && ((state == ST_OFF) || frame_end);
    assign take       = load && !fifo_empty && (!hs_en || cts);
    assign fifo_pop   = take;
    assign run        = (state != ST_OFF);
    assign next_byte  = take ? fifo_head : fill_byte;
    assign next_ninth = take;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:    if (enable) state_nx = ST_START;
            ST_START:  if (bit_done) state_nx = ST_DATA;
            ST_DATA:   if (bit_done && idx == IDXW'(W - 1)) state_nx = ST_NINTH;
            ST_NINTH:  if (bit_done) state_nx = par_en ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_done) state_nx = ST_STOP1;
            ST_STOP1:  if (bit_done) state_nx = stop2 ? ST_STOP2 : (enable ? ST_START : ST_OFF);
            ST_STOP2:  if (bit_done) state_nx = enable ? ST_START : ST_OFF;
            default:   state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            ninth   <= 1'b0;
            par_bit <= 1'b0;
            par_en  <= 1'b0;
            stop2   <= 1'b0;
            idx     <= '0;
        end else if (load) begin
            shreg   <= next_byte;
            ninth   <= next_ninth;
            par_bit <= (^{next_ninth, next_byte}) ^ (parity_mode == PAR_ODD);
            par_en  <= parity_on(parity_mode);
            stop2   <= two_stop;
            idx     <= '0;
        end else if (state == ST_DATA && bit_done) begin
            idx <= idx + 1'b1;
        end
    end

    always_comb begin
        txd    = 1'b1;
        txd_oe = 1'b1;
        unique case (state)
            ST_OFF:    txd_oe = 1'b0;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[idx];
            ST_NINTH:  txd = ninth;
            ST_PARITY: txd = par_bit;
            ST_STOP1,
            ST_STOP2:  txd = 1'b1;
            default:   txd_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/fill_uart_tx.sv
module fill_uart_tx #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 16,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fifo_full,
    output logic              fifo_empty,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [1:0]        parity_mode,
    input  logic              two_stop,
    input  logic [DATA_W-1:0] fill_byte,
    input  logic              hs_en,
    input  logic              cts,
    output logic              txd,
    output logic              txd_oe
);
    logic              fifo_pop;
    logic [DATA_W-1:0] fifo_head;
    logic              bit_done;
    logic              run;

    fill_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    fill_tx_baud #(.DIV_W(DIV_W), .OS(OVERSAMPLE)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .divisor  (divisor),
        .bit_done (bit_done)
    );

    fill_tx_fsm #(.W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .bit_done    (bit_done),
        .fifo_empty  (fifo_empty),
        .fifo_head   (fifo_head),
        .fill_byte   (fill_byte),
        .hs_en       (hs_en),
        .cts         (cts),
        .parity_mode (parity_mode),
        .two_stop    (two_stop),
        .fifo_pop    (fifo_pop),
        .run         (run),
        .txd         (txd),
        .txd_oe      (txd_oe)
    );
endmodule

// File: rtl/fill_uart_tx_checker.sv
module fill_uart_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic fifo_full,
    input logic fifo_empty,
    input logic fifo_pop,
    input logic hs_en,
    input logic cts,
    input logic bit_done,
    input logic txd,
    input logic txd_oe
);
    assert_released_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_oe |-> txd);

    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    assert_cts_blocks_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && hs_en) |-> cts);

    assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !fifo_pop) |=> fifo_full);

    assert_start_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txd_oe) |-> !txd);

    assert_bit_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_oe && $past(txd_oe) && !$stable(txd)) |-> $past(bit_done));
endmodule

bind fill_uart_tx fill_uart_tx_checker u_fill_uart_tx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .hs_en      (hs_en),
    .cts        (cts),
    .bit_done   (bit_done),
    .txd        (txd),
    .txd_oe     (txd_oe)
);

// File: tb/fill_uart_tx_bench.sv
`timescale 1ns/1ps
module fill_uart_tx_bench;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_full, fifo_empty;
    logic [15:0] divisor = '0;
    logic [1:0] parity_mode = '0;
    logic       two_stop = 1'b0;
    logic [7:0] fill_byte = 8'hA5;
    logic       hs_en = 1'b0;
    logic       cts = 1'b1;
    logic       txd, txd_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fill_uart_tx u_fill_uart_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .divisor(divisor),
        .parity_mode(parity_mode), .two_stop(two_stop), .fill_byte(fill_byte),
        .hs_en(hs_en), .cts(cts), .txd(txd), .txd_oe(txd_oe)
    );

    // reference model
    int    fq[$];
    bit    mb[$];
    string mt[$];
    bit    m_on = 1'b0;
    int    cyc = 0;

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic build_frame();
        int    b;
        bit    nb;
        bit    p;
        string tg;
        if (fq.size() > 0 && (!hs_en || cts)) begin
            b = fq.pop_front(); nb = 1'b1; tg = "R3";
        end else begin
            b = fill_byte; nb = 1'b0; tg = (fq.size() > 0) ? "R5" : "R1";
        end
        mb.push_back(1'b0); mt.push_back("R3");
        for (int i = 0; i < 8; i++) begin
            mb.push_back(b[i]); mt.push_back(tg);
        end
        mb.push_back(nb); mt.push_back(nb ? "R2" : tg);
        p = ^{nb, b[7:0]};
        if (parity_mode == 2'b01) begin mb.push_back(p);  mt.push_back("R6"); end
        if (parity_mode == 2'b10) begin mb.push_back(!p); mt.push_back("R6"); end
        mb.push_back(1'b1); mt.push_back("R3");
        if (two_stop) begin mb.push_back(1'b1); mt.push_back("R7"); end
    endtask

    task automatic model_edge();
        int pre;
        bit push, sel;
        int n;
        n   = (int'(divisor) + 1) * 16;
        pre = fq.size();
        push = wr_en && (pre < DEPTH);
        sel = 1'b0;
        if (!m_on) begin
            if (enable) sel = 1'b1;
        end else begin
            cyc++;
            if (cyc == n) begin
                cyc = 0;
                void'(mb.pop_front());
                void'(mt.pop_front());
                if (mb.size() == 0) begin
                    if (enable) sel = 1'b1;
                    else m_on = 1'b0;
                end
            end
        end
        if (sel) begin
            build_frame();
            m_on = 1'b1;
            cyc = 0;
        end
        if (push) fq.push_back(int'(wr_data));
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        #1;
        check("R8", int'(txd_oe), int'(m_on), "txd_oe");
        if (m_on) check(mt[0], int'(txd), int'(mb[0]), "txd");
        else      check("R8", int'(txd), 1, "txd released");
        check("R10", int'(fifo_full), int'(fq.size() == DEPTH), "fifo_full");
        check("R9", int'(fifo_empty), int'(fq.size() == 0), "fifo_empty");
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic put(logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic shut_down();
        int guard;
        guard = 0;
        enable = 1'b0;
        while ((m_on || txd_oe) && guard < 2000) begin
            tick();
            guard++;
        end
        check("R8", int'(txd_oe), 0, "released after disable");
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int n;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R11 reset state
        check("R11", int'(txd_oe), 0, "oe after reset");
        check("R11", int'(txd), 1, "txd after reset");
        check("R11", int'(fifo_empty), 1, "empty after reset");
        check("R11", int'(fifo_full), 0, "full after reset");
        run(5);

        // R1/R4: fill frames back to back
        enable = 1'b1;
        run(3 * 176);

        // R2/R9: payload while running
        put(8'h3C); put(8'h81); put(8'hFF);
        run(4 * 176);

        // R6/R7: parity modes and two stop bits
        parity_mode = 2'b01; put(8'h07); put(8'h00);
        run(3 * 192);
        parity_mode = 2'b10; two_stop = 1'b1; put(8'h6B); put(8'hFE);
        run(3 * 208);
        parity_mode = 2'b11; two_stop = 1'b0; put(8'h55);
        run(3 * 176);
        parity_mode = 2'b00;

        // R5/R10: blocked by cts, overfill FIFO
        hs_en = 1'b1; cts = 1'b0;
        put(8'h11); put(8'h22); put(8'h33); put(8'h44); put(8'h99); put(8'h98);
        check("R10", int'(fifo_full), 1, "full after overfill");
        run(2 * 176);
        cts = 1'b1;
        run(50);
        cts = 1'b0;
        run(300);
        cts = 1'b1;
        run(4 * 176);
        hs_en = 1'b0;

        // R8: disable mid-frame, frame completes
        run(60);
        shut_down();
        run(20);

        // R4: start-bit length with divisor 2
        divisor = 16'd2; fill_byte = 8'h55;
        enable = 1'b1;
        tick();
        n = 0;
        while (txd_oe && !txd && n < 1000) begin
            n++;
            tick();
        end
        check("R4", n, 48, "start bit length");
        run(3 * 48 * 11);
        shut_down();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule